// File: doc/BRIEF.md
# Floating-Point Reciprocal Exponent Unit

This unit produces the coarse reciprocal-exponent estimate used to seed iterative division and reciprocal sequences. For a finite or infinite operand it keeps the sign, writes the bitwise complement of the exponent field, and clears the fraction. It does not compute a true reciprocal: it only flips the scale of the operand so that a later step can multiply by it without overflow.

NaN operands are handled separately. A signalling NaN is made quiet and raises an invalid-operation flag. When the default-NaN mode bit is set, every NaN operand returns the canonical positive quiet NaN.

One operand is accepted per cycle on a valid strobe. The result and the flag are registered and appear on the following cycle. Both binary32 and binary64 are supported. A binary32 operand and its result sit in the low half of the 64-bit data ports.

Top module: `frecpx_unit`

## Requirements
- R1: An operand accepted with `inValid` high produces `outValid` high on the next clock cycle, together with `result` and `invalidFlag` for that operand. A cycle with `inValid` low gives `outValid` low on the next cycle.
- R2: Binary32 (`isDouble`=0), non-NaN operand with a nonzero exponent (field at bits 30:23): the result sign bit 31 equals the operand sign, the exponent field is the bitwise NOT of the operand exponent, and fraction bits 22:0 are zero.
- R3: An operand whose exponent field is all zeros (a zero or a subnormal) gives result exponent 0xFE for binary32 and 0x7FE for binary64. The sign is kept and the fraction is zero.
- R4: Binary64 (`isDouble`=1), non-NaN operand with a nonzero exponent (field at bits 62:52): the sign at bit 63 is kept, the exponent is inverted, and fraction bits 51:0 are zero.
- R5: An infinity (exponent all ones, fraction zero) gives a zero with the operand's sign. `invalidFlag` stays 0.
- R6: A signalling NaN (exponent all ones, nonzero fraction, top fraction bit 0) with `dnMode`=0 returns the operand with the top fraction bit (bit 22 or bit 51) set, and `invalidFlag`=1.
- R7: A quiet NaN (top fraction bit 1) with `dnMode`=0 is returned unchanged with `invalidFlag`=0.
- R8: With `dnMode`=1, any NaN returns 0x7FC00000 (binary32) or 0x7FF8000000000000 (binary64). `invalidFlag` is still 1 for a signalling NaN and 0 for a quiet NaN.
- R9: In binary32 mode, operand bits 63:32 have no effect and result bits 63:32 are zero.
- R10: After reset, `result`, `invalidFlag` and `outValid` are zero. While `inValid` is low, `result` and `invalidFlag` keep their last values whatever `opIn` does.
- R11: `invalidFlag` is 1 only for a signalling NaN operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operand valid strobe |
| opIn | input | 64 | Operand (binary32 in bits 31:0) |
| isDouble | input | 1 | 1 selects binary64, 0 selects binary32 |
| dnMode | input | 1 | Default-NaN mode |
| outValid | output | 1 | Result valid, one cycle after `inValid` |
| result | output | 64 | Estimate (binary32 in bits 31:0) |
| invalidFlag | output | 1 | Invalid operation raised by a signalling NaN |

## Verification
The hardest cases to reach are the NaN boundaries: a signalling NaN whose only set fraction bit is the lowest one, and a signalling NaN that arrives while default-NaN mode is on. In both cases the invalid flag must still be raised even though the payload is either kept or thrown away. Uniform random operands almost never hit an all-ones exponent. The stimulus therefore first picks an operand class (zero/subnormal, infinity, signalling NaN, quiet NaN, extreme exponent, or free), then fills in the fields. Directed cases pin the single-bit payloads, and binary32 operands always carry random junk in the upper half.

// File: rtl/fre_pkg.sv
package fre_pkg;
  localparam int DATA_W    = 64;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int SP_W      = 1 + SP_EXP_W + SP_FRAC_W;
  localparam int DP_W      = 1 + DP_EXP_W + DP_FRAC_W;

  typedef struct packed {
    logic load;
    logic dbl;
    logic dnMode;
  } freStrobe_t;
endpackage

// File: rtl/fre_format.sv
module fre_format #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] operand,
  input  logic                  dnMode,
  output logic [EXP_W+FRAC_W:0] value,
  output logic                  invalidOp
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic              signBit;
  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic              isNan;
  logic              isSignal;
  logic [EXP_W-1:0]  newExp;
  logic [W-1:0]      quietNan;
  logic [W-1:0]      defaultNan;

  always_comb begin
    signBit    = operand[W-1];
    expField   = operand[W-2 -: EXP_W];
    fracField  = operand[FRAC_W-1:0];
    isNan      = (&expField) && (|fracField);
    isSignal   = isNan && !fracField[FRAC_W-1];
    quietNan   = operand;
    quietNan[FRAC_W-1] = 1'b1;
    defaultNan = '0;
    defaultNan[W-2 -: EXP_W] = '1;
    defaultNan[FRAC_W-1] = 1'b1;
    newExp     = (expField == '0) ? {{(EXP_W-1){1'b1}}, 1'b0} : ~expField;
    if (isNan) begin
      value = dnMode ? defaultNan : quietNan;
    end else begin
      value = {signBit, newExp, {FRAC_W{1'b0}}};
    end
    invalidOp = isSignal;
  end
endmodule

// File: rtl/fre_ctrl.sv
module fre_ctrl
  import fre_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       isDouble,
  input  logic       dnMode,
  output freStrobe_t strobe,
  output logic       outValid
);
  always_comb begin
    strobe.load   = inValid;
    strobe.dbl    = isDouble;
    strobe.dnMode = dnMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/fre_datapath.sv
module fre_datapath
  import fre_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  freStrobe_t        strobe,
  input  logic [DATA_W-1:0] opIn,
  output logic [DATA_W-1:0] result,
  output logic              invalidFlag
);
  logic [SP_W-1:0]   spVal;
  logic              spInv;
  logic [DP_W-1:0]   dpVal;
  logic              dpInv;
  logic [DATA_W-1:0] nextResult;
  logic              nextInv;

  fre_format #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_sp (
    .operand(opIn[SP_W-1:0]), .dnMode(strobe.dnMode),
    .value(spVal), .invalidOp(spInv)
  );

  fre_format #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_dp (
    .operand(opIn[DP_W-1:0]), .dnMode(strobe.dnMode),
    .value(dpVal), .invalidOp(dpInv)
  );

  always_comb begin
    if (strobe.dbl) begin
      nextResult = dpVal;
      nextInv    = dpInv;
    end else begin
      nextResult = {{(DATA_W-SP_W){1'b0}}, spVal};
      nextInv    = spInv;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result      <= '0;
      invalidFlag <= 1'b0;
    end else if (strobe.load) begin
      result      <= nextResult;
      invalidFlag <= nextInv;
    end
  end
endmodule

// File: rtl/frecpx_unit.sv
module frecpx_unit
  import fre_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opIn,
  input  logic              isDouble,
  input  logic              dnMode,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              invalidFlag
);
  freStrobe_t strobe;

  fre_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .isDouble(isDouble),
    .dnMode(dnMode), .strobe(strobe), .outValid(outValid)
  );

  fre_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opIn(opIn),
    .result(result), .invalidFlag(invalidFlag)
  );
endmodule

// File: rtl/fre_checker.sv
module fre_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [63:0] opIn,
  input logic        isDouble,
  input logic        dnMode,
  input logic        outValid,
  input logic [63:0] result,
  input logic        invalidFlag
);
  logic spNan, dpNan, spSig, dpSig;
  always_comb begin
    spNan = (&opIn[30:23]) && (|opIn[22:0]);
    dpNan = (&opIn[62:52]) && (|opIn[51:0]);
    spSig = spNan && !opIn[22];
    dpSig = dpNan && !opIn[51];
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r2_sp_frac_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isDouble && !(&opIn[30:23])) |=> (result[22:0] == 23'd0));
  a_r4_dp_sign_kept: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isDouble && !dpNan) |=> (result[63] == $past(opIn[63])));
  a_r8_dp_default_nan: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isDouble && dnMode && dpNan) |=> (result == 64'h7FF8000000000000));
  a_r9_sp_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isDouble) |=> (result[63:32] == 32'd0));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(result) && $stable(invalidFlag)));
  a_r11_flag_sp: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isDouble) |=> (invalidFlag == $past(spSig)));
  a_r11_flag_dp: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isDouble) |=> (invalidFlag == $past(dpSig)));
endmodule

bind frecpx_unit fre_checker u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opIn(opIn),
  .isDouble(isDouble), .dnMode(dnMode), .outValid(outValid),
  .result(result), .invalidFlag(invalidFlag)
);

// File: tb/sim_frecpx_unit.sv
`timescale 1ns/1ps
module sim_frecpx_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] opIn = '0;
  logic        isDouble = 1'b0;
  logic        dnMode = 1'b0;
  logic        outValid;
  logic [63:0] result;
  logic        invalidFlag;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  frecpx_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opIn(opIn),
    .isDouble(isDouble), .dnMode(dnMode), .outValid(outValid),
    .result(result), .invalidFlag(invalidFlag)
  );

  // returns {flag, result}
  function automatic logic [64:0] refModel(logic [63:0] op, logic dbl, logic dn);
    logic [64:0] r;
    r = '0;
    if (dbl) begin
      if (op[62:52] == 11'h7FF && op[51:0] != 0) begin
        r[64] = !op[51];
        r[63:0] = dn ? 64'h7FF8000000000000 : (op | 64'h0008000000000000);
      end else if (op[62:52] == 11'h000) begin
        r[63:0] = {op[63], 11'h7FE, 52'd0};
      end else begin
        r[63:0] = {op[63], ~op[62:52], 52'd0};
      end
    end else begin
      if (op[30:23] == 8'hFF && op[22:0] != 0) begin
        r[64] = !op[22];
        r[31:0] = dn ? 32'h7FC00000 : (op[31:0] | 32'h00400000);
      end else if (op[30:23] == 8'h00) begin
        r[31:0] = {op[31], 8'hFE, 23'd0};
      end else begin
        r[31:0] = {op[31], ~op[30:23], 23'd0};
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [64:0] act,
                       input logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] op, input logic dbl, input logic dn,
                       input string tag);
    logic [64:0] e;
    e = refModel(op, dbl, dn);
    @(negedge clk);
    opIn = op; isDouble = dbl; dnMode = dn; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid === 1'b1, {"R1 valid ", tag}, {64'd0, outValid}, 65'd1);
    check({invalidFlag, result} === e, tag, {invalidFlag, result}, e);
  endtask

  function automatic logic [63:0] makeOp(int cls, logic dbl);
    logic [63:0] v;
    v = {$urandom, $urandom};
    if (dbl) begin
      case (cls)
        1: v[62:52] = 11'h000;
        2: begin v[62:52] = 11'h7FF; v[51:0] = 0; end
        3: begin v[62:52] = 11'h7FF; v[51] = 1'b0; if (v[50:0] == 0) v[0] = 1'b1; end
        4: begin v[62:52] = 11'h7FF; v[51] = 1'b1; end
        5: v[62:52] = v[0] ? 11'h7FE : 11'h001;
        default: ;
      endcase
    end else begin
      case (cls)
        1: v[30:23] = 8'h00;
        2: begin v[30:23] = 8'hFF; v[22:0] = 0; end
        3: begin v[30:23] = 8'hFF; v[22] = 1'b0; if (v[21:0] == 0) v[0] = 1'b1; end
        4: begin v[30:23] = 8'hFF; v[22] = 1'b1; end
        5: v[30:23] = v[0] ? 8'hFE : 8'h01;
        default: ;
      endcase
    end
    return v;
  endfunction

  function automatic string clsTag(int cls);
    case (cls)
      1: return "R3 zero/subnormal";
      2: return "R5 infinity";
      3: return "R6/R8/R11 signalling NaN";
      4: return "R7/R8 quiet NaN";
      default: return "R2/R4/R9 normal";
    endcase
  endfunction

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] held;
    logic        heldFlag;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(outValid === 1'b0 && result === 64'd0 && invalidFlag === 1'b0,
          "R10 reset", {invalidFlag, result}, 65'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0, "R1 idle after reset", {64'd0, outValid}, 65'd0);

    apply(64'h0000_0000_3F80_0000, 1'b0, 1'b0, "R2 sp 1.0");
    apply(64'h0000_0000_C120_0000, 1'b0, 1'b0, "R2 sp neg");
    apply(64'h0000_0000_8000_0000, 1'b0, 1'b0, "R3 sp -0");
    apply(64'h0000_0000_0000_0001, 1'b0, 1'b0, "R3 sp subnormal");
    apply(64'h8000_0000_0000_0000, 1'b1, 1'b0, "R3 dp -0");
    apply(64'h3FF0_0000_0000_0000, 1'b1, 1'b0, "R4 dp 1.0");
    apply(64'hC00A_BCDE_0000_0001, 1'b1, 1'b0, "R4 dp neg");
    apply(64'h0000_0000_FF80_0000, 1'b0, 1'b0, "R5 sp -inf");
    apply(64'h7FF0_0000_0000_0000, 1'b1, 1'b0, "R5 dp +inf");
    apply(64'h0000_0000_7F80_0001, 1'b0, 1'b0, "R6 sp sNaN lsb");
    apply(64'hFFF0_0000_0000_0001, 1'b1, 1'b0, "R6 dp sNaN lsb");
    apply(64'h0000_0000_FFC1_2345, 1'b0, 1'b0, "R7 sp qNaN");
    apply(64'h7FF8_0000_0000_00AB, 1'b1, 1'b0, "R7 dp qNaN");
    apply(64'h0000_0000_FF80_0001, 1'b0, 1'b1, "R8 sp sNaN dn");
    apply(64'hFFF0_0000_0000_0001, 1'b1, 1'b1, "R8 dp sNaN dn");
    apply(64'hFFFF_FFFF_FFC0_0007, 1'b0, 1'b1, "R8 sp qNaN dn");
    apply(64'h3FF0_0000_0000_0000, 1'b1, 1'b1, "R8 dn normal unaffected");
    apply(64'h7FF0_0000_3F80_0000, 1'b0, 1'b0, "R9 sp upper junk");
    apply(64'hFFFF_FFFF_0000_0000, 1'b0, 1'b0, "R9 sp upper junk zero");

    // R10 hold while idle
    held = result; heldFlag = invalidFlag;
    @(negedge clk);
    opIn = 64'hFFF0_0000_0000_0001; isDouble = 1'b1; dnMode = 1'b0;
    repeat (2) @(negedge clk);
    check(result === held && invalidFlag === heldFlag && outValid === 1'b0,
          "R10 hold while idle", {invalidFlag, result}, {heldFlag, held});

    for (int i = 0; i < 600; i++) begin
      int   cls;
      logic dbl;
      logic dn;
      cls = int'($urandom_range(0, 5));
      dbl = 1'($urandom);
      dn  = 1'($urandom);
      apply(makeOp(cls, dbl), dbl, dn, clsTag(cls));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule